// File: doc/BRIEF.md
# Parallel-Prefix Adder Logic Unit

This block is a small arithmetic/logic unit that works on two equal-width operands. A two-bit operation code selects one of three functions: bitwise AND, bitwise XOR, or binary addition with a carry-out. The operand width is a power of two and defaults to 8 bits.

Addition does not use a rippling carry. First, each bit produces a generate term (both bits set) and a propagate term (bits differ). A prefix tree then merges these pairs over log2(WIDTH) levels. At each level the span of every node doubles, and each node's span ends at its own bit. So after the last level, every bit position holds the carry into the bit above it. The sum bits are the propagate bits XORed with those carries.

The AND and XOR results are simply the generate and propagate vectors, so they need no logic of their own. A final multiplexer picks the result. An optional output register lets a clocked environment time the path at a 5 ns budget.

Top module: `ppa_logic_unit`

## Requirements
- R1: With op_sel = 2'b00, result equals the bitwise AND of a and b.
- R2: With op_sel = 2'b01, result equals the bitwise XOR of a and b.
- R3: With op_sel = 2'b10, result equals the low WIDTH bits of a + b (carry-in 0), and carry_out equals bit WIDTH of that sum.
- R4: With op_sel = 2'b11, result and carry_out are all zeros.
- R5: carry_out is 0 whenever op_sel is not 2'b10, including when the addition would overflow.
- R6: For the addition 8'b10101111 + 8'b10000101, result is 8'b00110100 and carry_out is 1.
- R7: For the XOR 8'b10101001 ^ 8'b10000000, result is 8'b00101001.
- R8: With REG_OUT = 1, result and carry_out show the function of the inputs present at the previous rising clock edge. While rst_n is low they are 0.
- R9: With REG_OUT = 0, result and carry_out follow the inputs combinationally, without a clock edge.
- R10: The same structure works for any power-of-two WIDTH. The prefix tree has $clog2(WIDTH) levels, built by generate loops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_sel | input | 2 | Operation code: 00 AND, 01 XOR, 10 ADD, 11 zero |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Addition carry-out, 0 for other operations |

## Verification
The main instance is built with WIDTH = 8 and REG_OUT = 1. At this size every operand pair (65,536 of them) fits in one pipelined sweep for each of the three live operations. That covers every carry chain the three-level prefix tree can form, including the full propagate run that spans all bits. A second instance is built with WIDTH = 4 and REG_OUT = 0. It is swept over all operand pairs and all four codes, which checks the combinational variant and a two-level tree from the same source. The reserved code and the two worked vectors are also run as directed cases.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_XOR  = 2'b01,
        OP_ADD  = 2'b10,
        OP_ZERO = 2'b11
    } op_e;

    // Group combine of a (generate, propagate) pair with the lower pair
    // adjacent to it. Returns {G, P}.
    function automatic logic [1:0] pg_merge(input logic g_hi, input logic p_hi,
                                            input logic g_lo, input logic p_lo);
        pg_merge = {g_hi | (p_hi & g_lo), p_hi & p_lo};
    endfunction

endpackage

// File: rtl/ppa_pg_stage.sv
module ppa_pg_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] ^ b[i];
    end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] carry_in_vec,   // carry into each bit
    output logic             carry_top       // carry out of the MSB
);
    import ppa_pkg::*;

    localparam int LEVELS = $clog2(WIDTH);

    // level l holds group terms whose span is 2**l bits ending at bit i
    logic [WIDTH-1:0] grp_g [LEVELS+1];
    logic [WIDTH-1:0] grp_p [LEVELS+1];

    assign grp_g[0] = gen;
    assign grp_p[0] = prop;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int DIST = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_node
            if (i >= DIST) begin : g_black
                logic [1:0] merged;
                assign merged          = pg_merge(grp_g[l][i], grp_p[l][i],
                                                  grp_g[l][i-DIST], grp_p[l][i-DIST]);
                assign grp_g[l+1][i]   = merged[1];
                assign grp_p[l+1][i]   = merged[0];
            end else begin : g_pass
                // span already reaches bit 0; carry-in is zero so P is dead
                assign grp_g[l+1][i]   = grp_g[l][i];
                assign grp_p[l+1][i]   = 1'b0;
            end
        end
    end

    assign carry_in_vec = {grp_g[LEVELS][WIDTH-2:0], 1'b0};
    assign carry_top    = grp_g[LEVELS][WIDTH-1];

    logic unused_p;
    assign unused_p = |grp_p[LEVELS];

endmodule

// File: rtl/ppa_sum_select.sv
module ppa_sum_select #(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] carry_in_vec,
    input  logic             carry_top,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    import ppa_pkg::*;

    logic [WIDTH-1:0] sum_bits;
    assign sum_bits = prop ^ carry_in_vec;

    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        unique case (op_e'(op_sel))
            OP_AND:  result = gen;
            OP_XOR:  result = prop;
            OP_ADD: begin
                result    = sum_bits;
                carry_out = carry_top;
            end
            OP_ZERO: begin
                result    = '0;
                carry_out = 1'b0;
            end
            default: begin
                result    = '0;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ppa_logic_unit.sv
module ppa_logic_unit #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    import ppa_pkg::*;

    localparam int SUMW = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cy;
    } out_t;

    logic [WIDTH-1:0] gen, prop, carry_in_vec, sel_res;
    logic             carry_top, sel_cy;

    ppa_pg_stage #(.WIDTH(WIDTH)) u_pg (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    ppa_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .gen          (gen),
        .prop         (prop),
        .carry_in_vec (carry_in_vec),
        .carry_top    (carry_top)
    );

    ppa_sum_select #(.WIDTH(WIDTH)) u_sel (
        .op_sel       (op_sel),
        .gen          (gen),
        .prop         (prop),
        .carry_in_vec (carry_in_vec),
        .carry_top    (carry_top),
        .result       (sel_res),
        .carry_out    (sel_cy)
    );

    // reference sum across the three separate stages
    logic [SUMW-1:0] ref_sum;
    assign ref_sum = {1'b0, a} + {1'b0, b};
    always_comb begin
        if (op_sel == OP_ADD) begin
            AST_PREFIX_SUM: assert ({sel_cy, sel_res} == ref_sum); // R3
        end
    end

    out_t out_d;
    always_comb begin
        out_d     = '0;
        out_d.res = sel_res;
        out_d.cy  = sel_cy;
    end

    if (REG_OUT) begin : g_reg
        out_t out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign result    = out_q.res;
        assign carry_out = out_q.cy;

        AST_AND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_AND) |=> (result == $past(a & b))); // R1
        AST_XOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_XOR) |=> (result == $past(a ^ b))); // R2
        AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == OP_ZERO) |=> (result == '0 && !carry_out)); // R4
        AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel != OP_ADD) |=> !carry_out); // R5
    end else begin : g_comb
        assign result    = out_d.res;
        assign carry_out = out_d.cy;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end

endmodule

// File: tb/tb_ppa_logic_unit.sv
module tb_ppa_logic_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] op_sel;
    logic [7:0] a, b, result;
    logic       carry_out;

    logic [1:0] op4;
    logic [3:0] a4, b4, res4;
    logic       cy4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ppa_logic_unit #(.WIDTH(8), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .a(a), .b(b),
        .result(result), .carry_out(carry_out)
    );

    ppa_logic_unit #(.WIDTH(4), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .op_sel(op4), .a(a4), .b(b4),
        .result(res4), .carry_out(cy4)
    );

    task automatic check(input string tag, input logic [7:0] act_r, input logic [7:0] exp_r,
                         input logic act_c, input logic exp_c);
        checks++;
        if (act_r !== exp_r || act_c !== exp_c) begin
            errors++;
            $display("FAIL %s: actual result=%b carry=%b expected result=%b carry=%b",
                     tag, act_r, act_c, exp_r, exp_c);
        end
    endtask

    function automatic logic [8:0] model8(input logic [1:0] op, input logic [7:0] x, input logic [7:0] y);
        case (op)
            2'b00:   model8 = {1'b0, x & y};
            2'b01:   model8 = {1'b0, x ^ y};
            2'b10:   model8 = {1'b0, x} + {1'b0, y};
            default: model8 = '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b00:   tag_of = "R1/R5 AND";
            2'b01:   tag_of = "R2/R5 XOR";
            2'b10:   tag_of = "R3 ADD";
            default: tag_of = "R4/R5 ZERO";
        endcase
    endfunction

    initial begin
        #(199_800 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] exp;
        logic [1:0] prev_op;
        bit         pending;
        rst_n = 1'b0; op_sel = 2'b10; a = 8'hFF; b = 8'hFF;
        op4 = 2'b00; a4 = '0; b4 = '0;
        pending = 1'b0; exp = '0; prev_op = '0;
        repeat (3) @(negedge clk);
        check("R8 reset", result, 8'h00, carry_out, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R5 R8: exhaustive pipelined sweep, one vector per cycle
        for (int op = 0; op < 3; op++) begin
            for (int v = 0; v < 65536; v++) begin
                @(negedge clk);
                if (pending) check(tag_of(prev_op), result, exp[7:0], carry_out, exp[8]);
                op_sel = 2'(op); a = v[15:8]; b = v[7:0];
                exp = model8(op_sel, a, b); prev_op = op_sel; pending = 1'b1;
            end
        end
        // R4 R5: reserved code, operands that would overflow if added
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            if (pending) check(tag_of(prev_op), result, exp[7:0], carry_out, exp[8]);
            op_sel = 2'b11; a = v[7:0]; b = 8'hFF;
            exp = 9'h000; prev_op = 2'b11; pending = 1'b1;
        end
        // R6: worked addition vector
        @(negedge clk);
        check(tag_of(prev_op), result, exp[7:0], carry_out, exp[8]);
        op_sel = 2'b10; a = 8'b10101111; b = 8'b10000101;
        @(negedge clk);
        check("R6 directed add", result, 8'b00110100, carry_out, 1'b1);
        // R7: worked XOR vector
        op_sel = 2'b01; a = 8'b10101001; b = 8'b10000000;
        @(negedge clk);
        check("R7 directed xor", result, 8'b00101001, carry_out, 1'b0);
        // R8: output holds until the next edge after an input change
        op_sel = 2'b00; a = 8'hF0; b = 8'h3C;
        #2;
        check("R8 hold before edge", result, 8'b00101001, carry_out, 1'b0);
        @(negedge clk);
        check("R8 one-cycle latency", result, 8'h30, carry_out, 1'b0);

        // R9 R10: combinational 4-bit instance, all codes and operand pairs
        for (int op = 0; op < 4; op++) begin
            for (int v = 0; v < 256; v++) begin
                logic [4:0] e4;
                op4 = 2'(op); a4 = v[7:4]; b4 = v[3:0];
                case (op)
                    0:       e4 = {1'b0, a4 & b4};
                    1:       e4 = {1'b0, a4 ^ b4};
                    2:       e4 = {1'b0, a4} + {1'b0, b4};
                    default: e4 = '0;
                endcase
                #5;
                check("R9/R10 width4 comb", {4'h0, res4}, {4'h0, e4[3:0]}, cy4, e4[4]);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule